// File: doc/BRIEF.md
# Dual-Issue Pairing Check

This block sits between instruction decode and two execution pipes: a primary pipe (U), which can run any instruction, and a secondary pipe (V), which runs only a restricted subset. It holds up to two decoded instructions in program order in a small two-slot queue. Each cycle it decides whether the older one may issue alone to U, or whether the younger one may go to V in the same cycle.

Pairing is allowed only under all of these conditions:

- both instructions are simple;
- the older one does not transfer control;
- the younger one needs no U-only resource;
- no register dependency links the two.

There is one permitted case among flag-related pairs: a condition-code producer followed by a conditional jump. A younger instruction left behind is held. It becomes the older instruction of the next decision, where it may pair with the instruction that follows it.

Decode feeds the queue through two ordered lanes, each with its own valid/ready. Lane 0 is the older instruction. Both pipes advance together under a single ready input.

Top module: `dual_issue_pair`

## Requirements
- R1: After reset the queue is empty. `u_valid`, `v_valid` and `hold` are low, and `in0_ready` is high.
- R2: `u_instr` always carries the oldest queued instruction and `v_instr` the next one, both unchanged. The descriptor bits are:
  - bit 0: simple
  - bit 1: U-only
  - bit 2: jump
  - bit 3: conditional jump
  - bit 4: sets condition codes
  - bit 5: destination valid
  - bit 6: source A valid
  - bit 7: source B valid
  - then, RW bits each: destination, source A, source B
  - the tag on top
- R3: A pair is refused unless both instructions have the simple bit set.
- R4: A pair is refused when the older instruction is a jump. A jump as the younger instruction may pair.
- R5: A pair is refused when the older instruction's valid destination equals a valid source of the younger one. A matching source whose valid bit is clear does not block.
- R6: A pair is refused when both instructions have valid destinations naming the same register.
- R7: A condition-code setter followed by a conditional jump pairs, provided the other rules allow it.
- R8: A younger instruction with the U-only bit is never placed in V. A U-only older instruction may still pair.
- R9: When two instructions are queued and refused, `hold` is high. After the U transfer, the held instruction moves to the U slot, where it may pair with the one accepted behind it.
- R10: With a single queued instruction, it is offered to U and `v_valid` stays low.
- R11: While `out_ready` is low nothing leaves the queue, and the offered U instruction stays unchanged.
- R12: Lane 0 is accepted when at least one slot is free after this cycle's issue. Lane 1 is accepted only with lane 0 and only when both slots are free.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in0_valid | input | 1 | Older incoming instruction present |
| in0_instr | input | DW (31) | Older incoming descriptor |
| in0_ready | output | 1 | Lane 0 accepted this cycle if valid |
| in1_valid | input | 1 | Younger incoming instruction present |
| in1_instr | input | DW (31) | Younger incoming descriptor |
| in1_ready | output | 1 | Lane 1 accepted this cycle if valid |
| out_ready | input | 1 | Both pipes take what is offered |
| u_valid | output | 1 | Instruction offered to U |
| u_instr | output | DW (31) | Descriptor for U |
| v_valid | output | 1 | Paired instruction offered to V |
| v_instr | output | DW (31) | Descriptor for V (second queue slot) |
| hold | output | 1 | Younger instruction refused and kept |

## Verification
The assertions assume that decode never raises lane 1 without lane 0, and that the jump, conditional-jump and U-only bits describe real instructions. The stimulus keeps to this: every driven pair presents lane 0 first. Random traffic draws register numbers from a range of four, so that read-after-write and write-after-write collisions occur often. Stalls are mixed in at random so that refused pairs and held instructions meet back-pressure.

// File: rtl/dual_issue_pair.sv
module dual_issue_pair #(
  parameter int RW   = 5,
  parameter int TAGW = 8
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      in0_valid,
  input  logic [8+3*RW+TAGW-1:0]    in0_instr,
  output logic                      in0_ready,
  input  logic                      in1_valid,
  input  logic [8+3*RW+TAGW-1:0]    in1_instr,
  output logic                      in1_ready,
  input  logic                      out_ready,
  output logic                      u_valid,
  output logic [8+3*RW+TAGW-1:0]    u_instr,
  output logic                      v_valid,
  output logic [8+3*RW+TAGW-1:0]    v_instr,
  output logic                      hold
);
  localparam int DW     = 8 + 3*RW + TAGW;
  localparam int F_SMP  = 0;
  localparam int F_UONL = 1;
  localparam int F_JMP  = 2;
  localparam int F_CJ   = 3;
  localparam int F_SCC  = 4;
  localparam int F_DV   = 5;
  localparam int F_AV   = 6;
  localparam int F_BV   = 7;
  localparam int DST_LO = 8;
  localparam int SA_LO  = 8 + RW;
  localparam int SB_LO  = 8 + 2*RW;

  logic [DW-1:0] slot0, slot1, n_slot0, n_slot1;
  logic [1:0]    occ, n_occ;

  logic both, raw_a, raw_b, waw, pair_ok;
  logic take_u, take_v;
  logic [1:0] cnt, rem;
  logic acc0, acc1;

  assign both  = occ[0] & occ[1];
  assign raw_a = slot0[F_DV] & slot1[F_AV] & (slot1[SA_LO +: RW] == slot0[DST_LO +: RW]);
  assign raw_b = slot0[F_DV] & slot1[F_BV] & (slot1[SB_LO +: RW] == slot0[DST_LO +: RW]);
  assign waw   = slot0[F_DV] & slot1[F_DV] & (slot1[DST_LO +: RW] == slot0[DST_LO +: RW]);

  assign pair_ok = both & slot0[F_SMP] & slot1[F_SMP] & ~slot0[F_JMP] & ~slot1[F_UONL]
                 & ~raw_a & ~raw_b & ~waw;

  assign u_valid = occ[0];
  assign u_instr = slot0;
  assign v_valid = pair_ok;
  assign v_instr = slot1;
  assign hold    = both & ~pair_ok;

  assign take_u = u_valid & out_ready;
  assign take_v = v_valid & out_ready;
  assign cnt    = {1'b0, occ[0]} + {1'b0, occ[1]};
  assign rem    = cnt - {1'b0, take_u} - {1'b0, take_v};

  assign in0_ready = (rem != 2'd2);
  assign in1_ready = (rem == 2'd0) & in0_valid;
  assign acc0      = in0_valid & in0_ready;
  assign acc1      = in1_valid & in1_ready;

  always_comb begin
    n_slot0 = slot0;
    n_slot1 = slot1;
    n_occ   = occ;
    if (take_v) begin
      n_occ = 2'b00;
    end else if (take_u) begin
      n_slot0 = slot1;
      n_occ   = {1'b0, occ[1]};
    end
    if (acc0) begin
      if (!n_occ[0]) begin
        n_slot0 = in0_instr;
        n_occ   = 2'b01;
        if (acc1) begin
          n_slot1 = in1_instr;
          n_occ   = 2'b11;
        end
      end else begin
        n_slot1 = in0_instr;
        n_occ   = 2'b11;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      occ   <= 2'b00;
      slot0 <= '0;
      slot1 <= '0;
    end else begin
      occ   <= n_occ;
      slot0 <= n_slot0;
      slot1 <= n_slot1;
    end
  end

  // R12
  occ_order_chk: assert property (@(posedge clk) disable iff (!rst_n) occ[1] |-> occ[0]);
  // R10
  v_needs_u_chk: assert property (@(posedge clk) disable iff (!rst_n) v_valid |-> u_valid);
  // R3
  simple_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> (u_instr[F_SMP] && v_instr[F_SMP]));
  // R4
  no_jump_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    v_valid |-> !u_instr[F_JMP]);
  // R6
  no_waw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (v_valid && u_instr[F_DV] && v_instr[F_DV]) |-> (u_instr[DST_LO +: RW] != v_instr[DST_LO +: RW]));
  // R8
  u_only_chk: assert property (@(posedge clk) disable iff (!rst_n) v_valid |-> !v_instr[F_UONL]);
  // R11
  stall_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (u_valid && !out_ready) |=> (u_valid && $stable(u_instr)));
  // R9
  hold_retry_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && out_ready) |=> (u_valid && u_instr == $past(v_instr)));
endmodule

// File: tb/sim_dual_issue_pair.sv
module sim_dual_issue_pair;
  localparam int RW = 5, TAGW = 8, DW = 8 + 3*RW + TAGW;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in0_valid = 0, in1_valid = 0, out_ready = 0;
  logic [DW-1:0] in0_instr = '0, in1_instr = '0;
  logic in0_ready, in1_ready, u_valid, v_valid, hold;
  logic [DW-1:0] u_instr, v_instr;

  always #2 clk = ~clk;

  dual_issue_pair #(.RW(RW), .TAGW(TAGW)) u0 (
    .clk(clk), .rst_n(rst_n),
    .in0_valid(in0_valid), .in0_instr(in0_instr), .in0_ready(in0_ready),
    .in1_valid(in1_valid), .in1_instr(in1_instr), .in1_ready(in1_ready),
    .out_ready(out_ready),
    .u_valid(u_valid), .u_instr(u_instr), .v_valid(v_valid), .v_instr(v_instr), .hold(hold));

  int runs = 0, fails = 0;
  logic [DW-1:0] expq[$];
  logic [7:0] tagc = 8'd1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mk(input bit smp, input bit uo, input bit jmp, input bit cj,
      input bit scc, input bit dv, input int d, input bit av, input int a, input bit bv, input int b);
    logic [DW-1:0] x;
    x = '0;
    x[0] = smp; x[1] = uo; x[2] = jmp; x[3] = cj; x[4] = scc;
    x[5] = dv; x[6] = av; x[7] = bv;
    x[8 +: RW] = RW'(d); x[8+RW +: RW] = RW'(a); x[8+2*RW +: RW] = RW'(b);
    x[8+3*RW +: TAGW] = tagc;
    tagc = tagc + 8'd1;
    return x;
  endfunction

  function automatic bit rule(input logic [DW-1:0] o, input logic [DW-1:0] y);
    bit ok;
    ok = o[0] && y[0] && !o[2] && !y[1];
    if (o[5] && y[6] && o[8 +: RW] == y[8+RW +: RW]) ok = 0;
    if (o[5] && y[7] && o[8 +: RW] == y[8+2*RW +: RW]) ok = 0;
    if (o[5] && y[5] && o[8 +: RW] == y[8 +: RW]) ok = 0;
    return ok;
  endfunction

  task automatic step(input string req, input bit v0, input logic [DW-1:0] d0,
                      input bit v1, input logic [DW-1:0] d1, input bit rdy);
    int n, pops, r;
    bit ep;
    @(negedge clk);
    in0_valid = v0; in0_instr = d0; in1_valid = v1; in1_instr = d1; out_ready = rdy;
    #1;
    n  = expq.size();
    ep = (n >= 2) && rule(expq[0], expq[1]);
    chk(u_valid == (n >= 1), req, "u_valid", 64'(u_valid), 64'(n >= 1));
    chk(v_valid == ep, req, "v_valid", 64'(v_valid), 64'(ep));
    chk(hold == ((n >= 2) && !ep), req, "hold", 64'(hold), 64'((n >= 2) && !ep));
    if (n >= 1) chk(u_instr == expq[0], req, "u_instr", 64'(u_instr), 64'(expq[0]));
    if (ep) chk(v_instr == expq[1], req, "v_instr", 64'(v_instr), 64'(expq[1]));
    pops = rdy ? ((n >= 1) + ep) : 0;
    r = n - pops;
    chk(in0_ready == (r <= 1), req, "in0_ready", 64'(in0_ready), 64'(r <= 1));
    chk(in1_ready == (r == 0 && v0), req, "in1_ready", 64'(in1_ready), 64'(r == 0 && v0));
    repeat (pops) void'(expq.pop_front());
    if (v0 && r <= 1) begin
      expq.push_back(d0);
      if (v1 && r == 0) expq.push_back(d1);
    end
    @(posedge clk);
  endtask

  task automatic idle(input string req, input bit rdy);
    step(req, 0, '0, 0, '0, rdy);
  endtask

  task automatic pair_case(input string req, input logic [DW-1:0] a, input logic [DW-1:0] b);
    step(req, 1, a, 1, b, 1);
    idle(req, 1);
    idle(req, 1);
    idle(req, 1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    logic [DW-1:0] a, b, c;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(!u_valid && !v_valid && !hold, "R1", "idle outputs", 64'({u_valid, v_valid, hold}), 64'(0));
    chk(in0_ready == 1'b1, "R1", "in0_ready", 64'(in0_ready), 64'(1));
    idle("R1", 1);

    // R2 independent simple pair
    pair_case("R2", mk(1,0,0,0,0,1,1,1,2,1,3), mk(1,0,0,0,0,1,4,1,5,1,6));
    // R3 complex older / younger
    pair_case("R3", mk(0,0,0,0,0,1,1,0,0,0,0), mk(1,0,0,0,0,1,2,0,0,0,0));
    pair_case("R3", mk(1,0,0,0,0,1,1,0,0,0,0), mk(0,0,0,0,0,1,2,0,0,0,0));
    // R4 jump older refused, jump younger pairs
    pair_case("R4", mk(1,0,1,0,0,0,0,0,0,0,0), mk(1,0,0,0,0,1,2,0,0,0,0));
    pair_case("R4", mk(1,0,0,0,0,1,2,0,0,0,0), mk(1,0,1,0,0,0,0,0,0,0,0));
    // R5 read-after-write on A, on B, and a masked source
    pair_case("R5", mk(1,0,0,0,0,1,7,0,0,0,0), mk(1,0,0,0,0,1,1,1,7,0,0));
    pair_case("R5", mk(1,0,0,0,0,1,7,0,0,0,0), mk(1,0,0,0,0,1,1,0,0,1,7));
    pair_case("R5", mk(1,0,0,0,0,1,7,0,0,0,0), mk(1,0,0,0,0,1,1,0,7,0,7));
    // R6 same destination refused, invalid older destination allowed
    pair_case("R6", mk(1,0,0,0,0,1,9,0,0,0,0), mk(1,0,0,0,0,1,9,0,0,0,0));
    pair_case("R6", mk(1,0,0,0,0,0,9,0,0,0,0), mk(1,0,0,0,0,1,9,0,0,0,0));
    // R7 flag setter then conditional jump
    pair_case("R7", mk(1,0,0,0,1,1,3,1,1,1,2), mk(1,0,1,1,0,0,0,0,0,0,0));
    // R8 U-only younger refused, U-only older pairs
    pair_case("R8", mk(1,0,0,0,0,1,1,0,0,0,0), mk(1,1,0,0,0,1,2,0,0,0,0));
    pair_case("R8", mk(1,1,0,0,0,1,1,0,0,0,0), mk(1,0,0,0,0,1,2,0,0,0,0));

    // R9 refused younger retried with the next instruction
    a = mk(1,0,0,0,0,1,4,0,0,0,0);
    b = mk(1,0,0,0,0,1,5,1,4,0,0);
    c = mk(1,0,0,0,0,1,6,1,1,0,0);
    step("R9", 1, a, 1, b, 1);
    step("R9", 1, c, 0, '0, 1);
    idle("R9", 1);
    idle("R9", 1);

    // R10 lone instruction
    step("R10", 1, mk(1,0,0,0,0,1,1,0,0,0,0), 0, '0, 1);
    idle("R10", 1);
    idle("R10", 1);

    // R11 stall keeps everything, full queue refuses input
    step("R11", 1, mk(1,0,0,0,0,1,1,0,0,0,0), 1, mk(1,0,0,0,0,1,2,0,0,0,0), 1);
    idle("R11", 0);
    step("R11", 1, mk(1,0,0,0,0,1,3,0,0,0,0), 0, '0, 0);
    idle("R11", 0);
    idle("R11", 1);
    idle("R11", 1);

    // R12 random traffic with back-pressure
    for (int i = 0; i < 400; i++) begin
      bit v0, v1;
      v0 = ($urandom_range(0, 3) != 0);
      v1 = v0 && ($urandom_range(0, 1) != 0);
      a = mk($urandom_range(0, 5) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
             $urandom_range(0, 1), $urandom_range(0, 3));
      b = mk($urandom_range(0, 5) != 0, $urandom_range(0, 5) == 0, $urandom_range(0, 5) == 0,
             $urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
             $urandom_range(0, 3), $urandom_range(0, 1), $urandom_range(0, 3),
             $urandom_range(0, 1), $urandom_range(0, 3));
      step("R12", v0, a, v1, b, $urandom_range(0, 3) != 0);
    end
    idle("R12", 1);
    idle("R12", 1);
    idle("R12", 1);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule